// File: doc/BRIEF.md
# Four-Port Expansion I/O Register Block

This block holds the data behind four 8-bit general purpose ports and presents them through a small register read/write interface. Port A is an output port whose drivers an external enable pin can float. Port B is an output port: its low nibble is push-pull and its high nibble is open drain. Port C is input only, and it also drives a combinational wake-up signal. Port D is bidirectional, and a control bit sets its direction.

The physical pads sit outside the block. For each pin the block supplies a data value and an output enable, and the pad ring turns these into drive or high impedance.

The register interface runs on its own bus clock, `clk`, and never on the system clock. Software reset and power management therefore cannot disturb the port state, and the ports stay readable and writable while the system clock is stopped. Only the hardware reset input `rst` initializes the registers.

Top module: `exp_io_block`

## Requirements
- R1: On the first `clk` edge with `rst` high, the port A, B and D data registers become all ones and port D enters input mode. After reset, `pa_o` is 0xFF, `pb_o` is 0x0F, `pb_oe` is 0x0F, `pd_oe` is 0x00, and a read of offset 4 returns 0x01.
- R2: A write to offset 0 (address `BASE`+0) loads the port A register on that edge. `pa_o` shows the register, and every bit of `pa_oe` equals the `oe_a` input.
- R3: Bits 3:0 of port B are push-pull: `pb_o[3:0]` follows the port B register and `pb_oe[3:0]` is always all ones.
- R4: Bits 7:4 of port B are open drain: `pb_o[7:4]` is always zero, and `pb_oe[i]` is the inverse of register bit i. A register 0 pulls the pin low; a register 1 leaves it floating.
- R5: A write to offset 5 (port A) or offset 6 (port B) is a single-bit write. `wdata[2:0]` selects the bit and `wdata[3]` gives its new value. No other bit of that register changes.
- R6: A read of offset 2 returns `pc_i` as it is at that moment. Writes to offset 2 have no effect.
- R7: `wake` is the combinational function pc_i[0] | pc_i[1] | pc_i[2] | pc_i[3] | ~pc_i[4] | ~pc_i[5] | ~pc_i[6] | ~pc_i[7].
- R8: Bit 0 of the control register at offset 4 (address 0x44) selects port D direction: 1 means input and 0 means output. `pd_oe` is all zeros in input mode and all ones in output mode. A read of offset 3 returns `pd_i` in input mode and the port D register in output mode. Writes to offset 3 update the register in either mode.
- R9: A register changes only on a write to its own offset. Writes elsewhere leave all port state unchanged. Reads of offsets 5 and 6 and of unmapped addresses return zero.
- R10: Asserting `rst` again at any time returns all registers to the R1 state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register bus clock; independent of the system clock |
| rst | input | 1 | Hardware reset, synchronous, active high |
| wr_en | input | 1 | Write strobe, sampled on `clk` |
| addr | input | 8 | Register address; the block decodes `BASE`..`BASE`+6 (BASE = 0x40) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| oe_a | input | 1 | External output enable for port A |
| pa_o | output | 8 | Port A pad data |
| pa_oe | output | 8 | Port A pad output enables |
| pb_o | output | 8 | Port B pad data |
| pb_oe | output | 8 | Port B pad output enables |
| pc_i | input | 8 | Port C pad inputs |
| wake | output | 1 | Wake-up signal derived from port C |
| pd_i | input | 8 | Port D pad inputs |
| pd_o | output | 8 | Port D pad data |
| pd_oe | output | 8 | Port D pad output enables |

## Verification
On every cycle, the assertions check that each write lands in the right register. They check that a single-bit write leaves the other bits alone, and that cycles without a write keep the pads stable. They also check the open-drain and direction mappings after the register writes that set them, and the state that hardware reset leaves behind.

Other behaviours depend on chosen input patterns, so only the bench scenarios can show them. These are the wake-up function across its boundary codes, the port D read-back choice between pins and register, the dropping of writes to the input port and to unmapped addresses, and the zero returned by reads there.

// File: rtl/exp_io_pkg.sv
package exp_io_pkg;

    // Register select; the value is the address offset from BASE.
    typedef enum logic [2:0] {
        SEL_PA     = 3'd0,
        SEL_PB     = 3'd1,
        SEL_PC     = 3'd2,
        SEL_PD     = 3'd3,
        SEL_CTL    = 3'd4,
        SEL_PA_BIT = 3'd5,
        SEL_PB_BIT = 3'd6,
        SEL_NONE   = 3'd7
    } reg_sel_e;

    localparam int unsigned NUM_SEL = 7;

    // Position of the direction bit inside the control register.
    localparam int unsigned CTL_DIR_BIT = 0;

    // Returns the register with bit 'idx' replaced by 'val'.
    function automatic logic [7:0] put_bit8(input logic [7:0] cur,
                                            input logic [2:0] idx,
                                            input logic       val);
        logic [7:0] res;
        res      = cur;
        res[idx] = val;
        return res;
    endfunction

endpackage

// File: rtl/exp_io_decode.sv
module exp_io_decode
    import exp_io_pkg::*;
#(
    parameter int unsigned AW   = 8,
    parameter logic [AW-1:0] BASE = 'h40
) (
    input  logic [AW-1:0] addr,
    output reg_sel_e      sel
);
    logic [AW-1:0] ofs;

    always_comb begin
        ofs = addr - BASE;
        if (addr >= BASE && ofs < AW'(NUM_SEL))
            sel = reg_sel_e'(ofs[2:0]);
        else
            sel = SEL_NONE;
    end
endmodule

// File: rtl/exp_io_regs.sv
module exp_io_regs
    import exp_io_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  reg_sel_e     sel,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] pa_q,
    output logic [W-1:0] pb_q,
    output logic [W-1:0] pd_q,
    output logic         pd_in_q
);
    localparam int unsigned IDXW = $clog2(W);

    logic [IDXW-1:0] bit_idx;
    logic            bit_val;
    logic [W-1:0]    bit_msk;

    assign bit_idx = wdata[IDXW-1:0];
    assign bit_val = wdata[IDXW];

    always_comb begin
        bit_msk = '0;
        bit_msk[bit_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pa_q    <= '1;
            pb_q    <= '1;
            pd_q    <= '1;
            pd_in_q <= 1'b1;
        end else if (wr_en) begin
            case (sel)
                SEL_PA:     pa_q <= wdata;
                SEL_PB:     pb_q <= wdata;
                SEL_PD:     pd_q <= wdata;
                SEL_CTL:    pd_in_q <= wdata[CTL_DIR_BIT];
                SEL_PA_BIT: pa_q <= (pa_q & ~bit_msk) | (bit_val ? bit_msk : '0);
                SEL_PB_BIT: pb_q <= (pb_q & ~bit_msk) | (bit_val ? bit_msk : '0);
                default:    ;
            endcase
        end
    end
endmodule

// File: rtl/exp_io_pads.sv
module exp_io_pads #(
    parameter int unsigned W = 8
) (
    input  logic         oe_a,
    input  logic [W-1:0] pa_q,
    input  logic [W-1:0] pb_q,
    input  logic [W-1:0] pd_q,
    input  logic         pd_in_q,
    input  logic [W-1:0] pc_i,
    output logic [W-1:0] pa_o,
    output logic [W-1:0] pa_oe,
    output logic [W-1:0] pb_o,
    output logic [W-1:0] pb_oe,
    output logic [W-1:0] pd_o,
    output logic [W-1:0] pd_oe,
    output logic         wake
);
    localparam int unsigned HALF = W / 2;

    assign pa_o  = pa_q;
    assign pa_oe = {W{oe_a}};
    assign pd_o  = pd_q;
    assign pd_oe = {W{~pd_in_q}};

    // Lower half of port B is push-pull; upper half is open drain.
    for (genvar i = 0; i < W; i++) begin : g_pb
        if (i < HALF) begin : g_pp
            assign pb_o[i]  = pb_q[i];
            assign pb_oe[i] = 1'b1;
        end else begin : g_od
            assign pb_o[i]  = 1'b0;
            assign pb_oe[i] = ~pb_q[i];
        end
    end

    // Wake when any low-half input is high or any high-half input is low.
    assign wake = (|pc_i[HALF-1:0]) | ~(&pc_i[W-1:HALF]);
endmodule

// File: rtl/exp_io_rdmux.sv
module exp_io_rdmux
    import exp_io_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  reg_sel_e     sel,
    input  logic [W-1:0] pa_q,
    input  logic [W-1:0] pb_q,
    input  logic [W-1:0] pd_q,
    input  logic         pd_in_q,
    input  logic [W-1:0] pc_i,
    input  logic [W-1:0] pd_i,
    output logic [W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        case (sel)
            SEL_PA:  rdata = pa_q;
            SEL_PB:  rdata = pb_q;
            SEL_PC:  rdata = pc_i;
            SEL_PD:  rdata = pd_in_q ? pd_i : pd_q;
            SEL_CTL: rdata[CTL_DIR_BIT] = pd_in_q;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/exp_io_block.sv
module exp_io_block
    import exp_io_pkg::*;
#(
    parameter int unsigned   W    = 8,
    parameter int unsigned   AW   = 8,
    parameter logic [AW-1:0] BASE = 'h40
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    input  logic          oe_a,
    output logic [W-1:0]  pa_o,
    output logic [W-1:0]  pa_oe,
    output logic [W-1:0]  pb_o,
    output logic [W-1:0]  pb_oe,
    input  logic [W-1:0]  pc_i,
    output logic          wake,
    input  logic [W-1:0]  pd_i,
    output logic [W-1:0]  pd_o,
    output logic [W-1:0]  pd_oe
);
    reg_sel_e     sel;
    logic [W-1:0] pa_q, pb_q, pd_q;
    logic         pd_in_q;

    exp_io_decode #(.AW(AW), .BASE(BASE)) u_dec (
        .addr (addr),
        .sel  (sel)
    );

    exp_io_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .sel     (sel),
        .wdata   (wdata),
        .pa_q    (pa_q),
        .pb_q    (pb_q),
        .pd_q    (pd_q),
        .pd_in_q (pd_in_q)
    );

    exp_io_pads #(.W(W)) u_pads (
        .oe_a    (oe_a),
        .pa_q    (pa_q),
        .pb_q    (pb_q),
        .pd_q    (pd_q),
        .pd_in_q (pd_in_q),
        .pc_i    (pc_i),
        .pa_o    (pa_o),
        .pa_oe   (pa_oe),
        .pb_o    (pb_o),
        .pb_oe   (pb_oe),
        .pd_o    (pd_o),
        .pd_oe   (pd_oe),
        .wake    (wake)
    );

    exp_io_rdmux #(.W(W)) u_rd (
        .sel     (sel),
        .pa_q    (pa_q),
        .pb_q    (pb_q),
        .pd_q    (pd_q),
        .pd_in_q (pd_in_q),
        .pc_i    (pc_i),
        .pd_i    (pd_i),
        .rdata   (rdata)
    );
endmodule

// File: rtl/exp_io_chk.sv
module exp_io_chk #(
    parameter int unsigned   W    = 8,
    parameter int unsigned   AW   = 8,
    parameter logic [AW-1:0] BASE = 'h40
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [AW-1:0] addr,
    input logic [W-1:0]  wdata,
    input logic [W-1:0]  pa_o,
    input logic [W-1:0]  pb_oe,
    input logic [W-1:0]  pd_o,
    input logic [W-1:0]  pd_oe
);
    localparam int unsigned IDXW = $clog2(W);
    localparam int unsigned HALF = W / 2;

    logic [W-1:0] msk;
    always_comb begin
        msk = '0;
        msk[wdata[IDXW-1:0]] = 1'b1;
    end

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $fell(rst) |-> (pa_o == '1 && pd_o == '1 && pd_oe == '0));

    // R10
    rereset_chk: assert property (@(posedge clk)
        $rose(rst) |=> (pa_o == '1 && pd_oe == '0));

    // R2
    pa_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == BASE) |=> (pa_o == $past(wdata)));

    // R4
    pb_od_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == BASE + AW'(1)) |=>
            (pb_oe[W-1:HALF] == ~$past(wdata[W-1:HALF])));

    // R5
    pa_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == BASE + AW'(5)) |=>
            (((pa_o & ~$past(msk)) == ($past(pa_o) & ~$past(msk))) &&
             (((pa_o & $past(msk)) != '0) == $past(wdata[IDXW]))));

    // R8
    pd_dir_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == BASE + AW'(4)) |=> (pd_oe == {W{~$past(wdata[0])}}));

    // R9
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(pa_o) && $stable(pb_oe) && $stable(pd_o) && $stable(pd_oe)));
endmodule

bind exp_io_block exp_io_chk #(.W(W), .AW(AW), .BASE(BASE)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .pa_o  (pa_o),
    .pb_oe (pb_oe),
    .pd_o  (pd_o),
    .pd_oe (pd_oe)
);

// File: tb/sim_exp_io_block.sv
`timescale 1ns/1ps
module sim_exp_io_block;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       oe_a = 1'b1;
    logic [7:0] pa_o, pa_oe, pb_o, pb_oe, pd_o, pd_oe;
    logic [7:0] pc_i = 8'h5A;
    logic [7:0] pd_i = 8'hC3;
    logic       wake;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    exp_io_block u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .oe_a(oe_a), .pa_o(pa_o), .pa_oe(pa_oe),
        .pb_o(pb_o), .pb_oe(pb_oe), .pc_i(pc_i), .wake(wake),
        .pd_i(pd_i), .pd_o(pd_o), .pd_oe(pd_oe)
    );

    // Each entry: {write address, write data, read address, expected read data}
    localparam logic [31:0] VEC [12] = '{
        {8'h40, 8'h3C, 8'h40, 8'h3C},   // R2 byte write port A
        {8'h45, 8'h08, 8'h40, 8'h3D},   // R5 set A bit 0
        {8'h45, 8'h05, 8'h40, 8'h1D},   // R5 clear A bit 5
        {8'h41, 8'hA5, 8'h41, 8'hA5},   // R3 byte write port B
        {8'h46, 8'h07, 8'h41, 8'h25},   // R5 clear B bit 7
        {8'h46, 8'h09, 8'h41, 8'h27},   // R5 set B bit 1
        {8'h43, 8'h96, 8'h43, 8'hC3},   // R8 input mode reads pins
        {8'h44, 8'h00, 8'h43, 8'h96},   // R8 output mode reads register
        {8'h47, 8'hFF, 8'h40, 8'h1D},   // R9 unmapped write ignored
        {8'h42, 8'h00, 8'h42, 8'h5A},   // R6 port C not writable
        {8'h48, 8'h11, 8'h45, 8'h00},   // R9 bit-write offset reads zero
        {8'h44, 8'h01, 8'h44, 8'h01}    // R8 back to input mode
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        addr = 8'h44; #1;
        check("R1 ctl", rdata, 8'h01);
        check("R1 pa_o", pa_o, 8'hFF);
        check("R1 pb_o", pb_o, 8'h0F);
        check("R1 pb_oe", pb_oe, 8'h0F);
        check("R1 pd_oe", pd_oe, 8'h00);
        check("R2 pa_oe", pa_oe, 8'hFF);

        for (int i = 0; i < 12; i++) begin
            wr(VEC[i][31:24], VEC[i][23:16]);
            addr = VEC[i][15:8]; #1;
            check($sformatf("vector %0d (R2/R5/R6/R8/R9)", i), rdata, VEC[i][7:0]);
        end

        // Pad views after the table
        check("R2 pa_o", pa_o, 8'h1D);
        oe_a = 1'b0; #1;
        check("R2 pa_oe off", pa_oe, 8'h00);
        check("R3 pb_o", pb_o, 8'h07);
        check("R4 pb_oe", pb_oe, 8'hDF);
        check("R8 pd_oe input", pd_oe, 8'h00);
        check("R8 pd_o", pd_o, 8'h96);
        wr(8'h44, 8'h00); #1;
        check("R8 pd_oe output", pd_oe, 8'hFF);

        // R7 wake boundary codes
        pc_i = 8'hF0; #1; check("R7 F0", {7'd0, wake}, 8'h00);
        pc_i = 8'hF1; #1; check("R7 F1", {7'd0, wake}, 8'h01);
        pc_i = 8'hF8; #1; check("R7 F8", {7'd0, wake}, 8'h01);
        pc_i = 8'h70; #1; check("R7 70", {7'd0, wake}, 8'h01);
        pc_i = 8'hE0; #1; check("R7 E0", {7'd0, wake}, 8'h01);
        pc_i = 8'h00; #1; check("R7 00", {7'd0, wake}, 8'h01);
        addr = 8'h42; #1; check("R6 live read", rdata, 8'h00);

        // R10 reset while running
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        addr = 8'h41; #1;
        check("R10 pb", rdata, 8'hFF);
        check("R10 pa_o", pa_o, 8'hFF);
        check("R10 pd_oe", pd_oe, 8'h00);
        addr = 8'h43; #1;
        check("R10 pd reads pins", rdata, 8'hC3);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule